// File: doc/BRIEF.md
# Address Range Decoder with Default Port

The decoder turns a lookup address into the index of the destination port that serves it. Each destination port loads one or more inclusive address ranges into a shared table. It then reports that its set is complete with a per-port strobe. Lookups are served only after every port has reported. A small recent-match cache sits in front of the table. A cache hit returns the result one cycle after the request. A lookup that has to search the table returns it two cycles after the request.

One port, set by a parameter, can be enabled as the default port. When it is enabled, its range writes do not go into the table. Instead they set a single default range. If an address matches no table entry, one of two things happens. With default-range mode on, the address goes to the default port only when it falls inside the default range. With the mode off, every such address goes to the default port.

Range writes are checked against the ranges other ports already own. A port can replace its whole set at any moment. An export view lists the ranges the decoder serves: the default range at index 0, then every table range that does not lie inside it. A table write with no free slot is refused and reports error code 3.

Top module: `addr_route_dec`

## Requirements
- R1: Until every port has pulsed `done_valid` at least once, an accepted lookup returns `rsp_err`=1 one cycle after acceptance.
- R2: A lookup that misses the cache searches the table and responds two cycles after acceptance. A table hit loads the matching range and its port into the cache, so a repeat lookup in that range responds after one cycle with the same port and `rsp_dflt`=0.
- R3: With the default port enabled and default-range mode on, an address that matches no table entry but lies inside the default range returns the default port with `rsp_dflt`=1.
- R4: With the default port enabled and default-range mode off, an address that matches no table entry returns the default port with `rsp_dflt`=1.
- R5: An address that resolves to no port returns `rsp_err`=1. This happens when it misses the default range in default-range mode, or when no default port is enabled.
- R6: A write with `prog_first`=1 removes every table entry owned by that port before the new range is inserted.
- R7: A table write whose range overlaps a range owned by a different port is not inserted, and the next cycle shows `cfg_err_valid`=1 with `cfg_err_code`=1.
- R8: While the default port is enabled, a default-port write with `prog_first`=0 is ignored, and the next cycle shows `cfg_err_valid`=1 with `cfg_err_code`=2.
- R9: Every range write and every `done_valid` strobe empties the cache, so the next lookup takes two cycles.
- R10: `contain_err` is 1 when all of the following hold: all ports have reported, the default port is enabled, and default-range mode is on, and in addition either some table range intersects the default range without lying inside it, or no default range has been written. Otherwise it is 0.
- R11: Export index 0 gives the default range. Index k≥1 gives the k-th valid table entry, in slot order, that is not inside the default range. The inside test applies only in default-range mode. `exp_cnt` counts those table entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dflt_en | input | 1 | Default port enabled |
| cfg_drange_on | input | 1 | Default-range mode |
| prog_valid | input | 1 | Range write strobe |
| prog_first | input | 1 | First range of a new set for this port |
| prog_port | input | PW | Port owning the range |
| prog_base | input | AW | Inclusive range start |
| prog_end | input | AW | Inclusive range end |
| done_valid | input | 1 | Port has finished reporting |
| done_port | input | PW | Port reporting completion |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | AW | Lookup address |
| lk_ready | output | 1 | Lookup can be accepted |
| rsp_valid | output | 1 | Lookup response strobe |
| rsp_port | output | PW | Resolved port |
| rsp_dflt | output | 1 | Routed through the default path |
| rsp_err | output | 1 | No port resolved |
| cfg_err_valid | output | 1 | Write error pulse |
| cfg_err_code | output | 2 | 1 overlap, 2 extra default range, 3 table full |
| contain_err | output | 1 | Default-range containment violation |
| exp_idx | input | XW | Export view index |
| exp_valid | output | 1 | Indexed export entry exists |
| exp_base | output | AW | Export entry start |
| exp_end | output | AW | Export entry end |
| exp_cnt | output | CW | Exported table ranges |

## Verification
The cycle a lookup response arrives encodes the path it took. It appears on the first falling edge after the accepting rising edge for a refusal or a cache hit. It appears one edge later for a table search. The bench records which of those two edges shows `rsp_valid` and compares that latency as well as the result. Write errors are registered, so each write task checks `cfg_err_valid` at the falling edge right after its write edge. Containment and export outputs are combinational over the stored state, so the bench samples them one falling edge after the update that changes that state.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;

  typedef logic [63:0] wide_addr_t;

  typedef enum logic [1:0] {
    CE_NONE       = 2'd0,
    CE_OVERLAP    = 2'd1,
    CE_MULTI_DFLT = 2'd2,
    CE_FULL       = 2'd3
  } cfg_err_e;

  function automatic logic rng_has(wide_addr_t lo, wide_addr_t hi, wide_addr_t a);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic rng_meet(wide_addr_t lo1, wide_addr_t hi1,
                                    wide_addr_t lo2, wide_addr_t hi2);
    return (lo1 <= hi2) && (lo2 <= hi1);
  endfunction

  function automatic logic rng_inside(wide_addr_t lo, wide_addr_t hi,
                                      wide_addr_t olo, wide_addr_t ohi);
    return (lo >= olo) && (hi <= ohi);
  endfunction

endpackage

// File: rtl/addr_route_table.sv
module addr_route_table
  import addr_route_pkg::*;
#(
  parameter int NP    = 4,
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_first,
  input  logic [PW-1:0] wr_port,
  input  logic [AW-1:0] wr_base,
  input  logic [AW-1:0] wr_end,
  output logic          wr_overlap,
  output logic          wr_full,
  input  logic [AW-1:0] srch_addr,
  output logic          srch_hit,
  output logic [PW-1:0] srch_port,
  output logic [AW-1:0] srch_base,
  output logic [AW-1:0] srch_end,
  input  logic          chk_on,
  input  logic [AW-1:0] chk_base,
  input  logic [AW-1:0] chk_end,
  output logic          chk_bad,
  input  logic          sub_on,
  input  logic [CW-1:0] exp_idx,
  output logic          exp_valid,
  output logic [AW-1:0] exp_base,
  output logic [AW-1:0] exp_end,
  output logic [CW-1:0] exp_cnt
);

  logic [DEPTH-1:0] ent_vld;
  logic [PW-1:0]    ent_port [DEPTH];
  logic [AW-1:0]    ent_base [DEPTH];
  logic [AW-1:0]    ent_end  [DEPTH];

  // entries released by a first-of-set write
  logic [DEPTH-1:0] gone;
  logic             slot_found;
  logic [CW-1:0]    slot_idx;

  always_comb begin
    wr_overlap = 1'b0;
    slot_found = 1'b0;
    slot_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      gone[i] = wr_en && wr_first && ent_vld[i] && (ent_port[i] == wr_port);
      if (wr_en && ent_vld[i] && (ent_port[i] != wr_port) &&
          rng_meet(64'(ent_base[i]), 64'(ent_end[i]), 64'(wr_base), 64'(wr_end)))
        wr_overlap = 1'b1;
      if (!slot_found && (!ent_vld[i] || gone[i])) begin
        slot_found = 1'b1;
        slot_idx   = CW'(i);
      end
    end
    wr_full = wr_en && !slot_found;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ent_port[i] <= '0;
        ent_base[i] <= '0;
        ent_end[i]  <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (gone[i]) ent_vld[i] <= 1'b0;
        if (!wr_overlap && slot_found && (slot_idx == CW'(i))) begin
          ent_vld[i]  <= 1'b1;
          ent_port[i] <= wr_port;
          ent_base[i] <= wr_base;
          ent_end[i]  <= wr_end;
        end
      end
    end
  end

  // search: lowest matching slot
  always_comb begin
    srch_hit  = 1'b0;
    srch_port = '0;
    srch_base = '0;
    srch_end  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!srch_hit && ent_vld[i] &&
          rng_has(64'(ent_base[i]), 64'(ent_end[i]), 64'(srch_addr))) begin
        srch_hit  = 1'b1;
        srch_port = ent_port[i];
        srch_base = ent_base[i];
        srch_end  = ent_end[i];
      end
    end
  end

  // containment: partial overlap with the default range
  always_comb begin
    chk_bad = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (chk_on && ent_vld[i] &&
          rng_meet(64'(ent_base[i]), 64'(ent_end[i]), 64'(chk_base), 64'(chk_end)) &&
          !rng_inside(64'(ent_base[i]), 64'(ent_end[i]), 64'(chk_base), 64'(chk_end)))
        chk_bad = 1'b1;
    end
  end

  // export view: compacted list of entries not inside the default range
  always_comb begin
    exp_valid = 1'b0;
    exp_base  = '0;
    exp_end   = '0;
    exp_cnt   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_vld[i] &&
          !(sub_on && rng_inside(64'(ent_base[i]), 64'(ent_end[i]),
                                 64'(chk_base), 64'(chk_end)))) begin
        if (exp_cnt == exp_idx) begin
          exp_valid = 1'b1;
          exp_base  = ent_base[i];
          exp_end   = ent_end[i];
        end
        exp_cnt = exp_cnt + CW'(1);
      end
    end
  end

  // R7: a refused overlapping write never grows the table
  a_r7_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_overlap) |=> ($countones(ent_vld) <= $past($countones(ent_vld))));

  // R6: after a first-of-set write, at most one entry of that port remains
  a_r6_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_first) |=> !ent_vld[$past(slot_idx)] || $past(wr_overlap) ||
                            (ent_port[$past(slot_idx)] == $past(wr_port)));

endmodule

// File: rtl/addr_route_cache.sv
module addr_route_cache
  import addr_route_pkg::*;
#(
  parameter int AW    = 16,
  parameter int PW    = 2,
  parameter int DEPTH = 2,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_base,
  input  logic [AW-1:0] ld_end,
  input  logic [PW-1:0] ld_port,
  input  logic [AW-1:0] q_addr,
  output logic          q_hit,
  output logic [PW-1:0] q_port
);

  logic [DEPTH-1:0] cv;
  logic [AW-1:0]    cbase [DEPTH];
  logic [AW-1:0]    cend  [DEPTH];
  logic [PW-1:0]    cport [DEPTH];
  logic [IW-1:0]    ptr;

  always_comb begin
    q_hit  = 1'b0;
    q_port = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!q_hit && cv[i] && rng_has(64'(cbase[i]), 64'(cend[i]), 64'(q_addr))) begin
        q_hit  = 1'b1;
        q_port = cport[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cv  <= '0;
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        cbase[i] <= '0;
        cend[i]  <= '0;
        cport[i] <= '0;
      end
    end else if (flush) begin
      cv <= '0;
    end else if (ld_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ptr == IW'(i)) begin
          cv[i]    <= 1'b1;
          cbase[i] <= ld_base;
          cend[i]  <= ld_end;
          cport[i] <= ld_port;
        end
      end
      ptr <= (ptr == IW'(DEPTH - 1)) ? '0 : ptr + IW'(1);
    end
  end

  // R9: a flush leaves no live cache line
  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ($countones(cv) == 0));

endmodule

// File: rtl/addr_route_dec.sv
module addr_route_dec
  import addr_route_pkg::*;
#(
  parameter int NP        = 4,
  parameter int AW        = 16,
  parameter int TBL_DEPTH = 8,
  parameter int CACHE_DEPTH = 2,
  parameter int DFLT_PORT = 3,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int CW = $clog2(TBL_DEPTH + 1),
  localparam int XW = $clog2(TBL_DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dflt_en,
  input  logic          cfg_drange_on,
  input  logic          prog_valid,
  input  logic          prog_first,
  input  logic [PW-1:0] prog_port,
  input  logic [AW-1:0] prog_base,
  input  logic [AW-1:0] prog_end,
  input  logic          done_valid,
  input  logic [PW-1:0] done_port,
  input  logic          lk_req,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_ready,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_port,
  output logic          rsp_dflt,
  output logic          rsp_err,
  output logic          cfg_err_valid,
  output logic [1:0]    cfg_err_code,
  output logic          contain_err,
  input  logic [XW-1:0] exp_idx,
  output logic          exp_valid,
  output logic [AW-1:0] exp_base,
  output logic [AW-1:0] exp_end,
  output logic [CW-1:0] exp_cnt
);

  localparam logic [PW-1:0] DP = PW'(DFLT_PORT);

  // readiness
  logic [NP-1:0] rep_q;
  logic          all_rep;
  assign all_rep = &rep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rep_q <= '0;
    else if (done_valid) rep_q[done_port] <= 1'b1;
  end

  // write steering and default range
  logic          dflt_wr, tbl_wr, multi_dflt;
  logic          dflt_set_q;
  logic [AW-1:0] dflt_base_q, dflt_end_q;

  assign dflt_wr    = prog_valid && cfg_dflt_en && (prog_port == DP);
  assign tbl_wr     = prog_valid && !dflt_wr;
  assign multi_dflt = dflt_wr && !prog_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dflt_set_q  <= 1'b0;
      dflt_base_q <= '0;
      dflt_end_q  <= '0;
    end else if (dflt_wr && prog_first) begin
      dflt_set_q  <= 1'b1;
      dflt_base_q <= prog_base;
      dflt_end_q  <= prog_end;
    end
  end

  // table
  logic          wr_overlap, wr_full;
  logic          s2_q;
  logic [AW-1:0] s2_addr_q;
  logic          srch_hit;
  logic [PW-1:0] srch_port;
  logic [AW-1:0] srch_base, srch_end;
  logic          chk_on, chk_bad, sub_on;
  logic [XW-1:0] idx_m1;
  logic          t_exp_valid;
  logic [AW-1:0] t_exp_base, t_exp_end;

  assign chk_on = all_rep && cfg_dflt_en && cfg_drange_on && dflt_set_q;
  assign sub_on = cfg_dflt_en && cfg_drange_on && dflt_set_q;
  assign idx_m1 = exp_idx - XW'(1);

  addr_route_table #(.NP(NP), .AW(AW), .DEPTH(TBL_DEPTH)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_wr), .wr_first(prog_first), .wr_port(prog_port),
    .wr_base(prog_base), .wr_end(prog_end),
    .wr_overlap(wr_overlap), .wr_full(wr_full),
    .srch_addr(s2_addr_q), .srch_hit(srch_hit), .srch_port(srch_port),
    .srch_base(srch_base), .srch_end(srch_end),
    .chk_on(chk_on), .chk_base(dflt_base_q), .chk_end(dflt_end_q), .chk_bad(chk_bad),
    .sub_on(sub_on), .exp_idx(CW'(idx_m1)),
    .exp_valid(t_exp_valid), .exp_base(t_exp_base), .exp_end(t_exp_end),
    .exp_cnt(exp_cnt)
  );

  assign contain_err = all_rep && cfg_dflt_en && cfg_drange_on && (chk_bad || !dflt_set_q);

  always_comb begin
    if (exp_idx == '0) begin
      exp_valid = dflt_set_q && cfg_dflt_en;
      exp_base  = dflt_base_q;
      exp_end   = dflt_end_q;
    end else begin
      exp_valid = t_exp_valid;
      exp_base  = t_exp_base;
      exp_end   = t_exp_end;
    end
  end

  // write error pulse
  cfg_err_e err_nxt;
  logic     cfg_err_valid_q;
  cfg_err_e cfg_err_code_q;

  always_comb begin
    if (tbl_wr && wr_overlap)   err_nxt = CE_OVERLAP;
    else if (tbl_wr && wr_full) err_nxt = CE_FULL;
    else if (multi_dflt)        err_nxt = CE_MULTI_DFLT;
    else                        err_nxt = CE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_err_valid_q <= 1'b0;
      cfg_err_code_q  <= CE_NONE;
    end else begin
      cfg_err_valid_q <= (err_nxt != CE_NONE);
      cfg_err_code_q  <= err_nxt;
    end
  end

  assign cfg_err_valid = cfg_err_valid_q;
  assign cfg_err_code  = cfg_err_code_q;

  // cache
  logic          flush, c_hit, acc;
  logic [PW-1:0] c_port;

  assign flush = prog_valid || done_valid;

  addr_route_cache #(.AW(AW), .PW(PW), .DEPTH(CACHE_DEPTH)) u_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ld_en(s2_q && srch_hit), .ld_base(srch_base), .ld_end(srch_end), .ld_port(srch_port),
    .q_addr(lk_addr), .q_hit(c_hit), .q_port(c_port)
  );

  // lookup pipeline
  logic          rsp_valid_q, rsp_dflt_q, rsp_err_q;
  logic [PW-1:0] rsp_port_q;
  logic          in_drange;

  assign lk_ready  = !s2_q;
  assign acc       = lk_req && lk_ready;
  assign in_drange = dflt_set_q && rng_has(64'(dflt_base_q), 64'(dflt_end_q), 64'(s2_addr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_q        <= 1'b0;
      s2_addr_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_port_q  <= '0;
      rsp_dflt_q  <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      s2_q        <= 1'b0;
      if (s2_q) begin
        rsp_valid_q <= 1'b1;
        if (srch_hit) begin
          rsp_port_q <= srch_port; rsp_dflt_q <= 1'b0; rsp_err_q <= 1'b0;
        end else if (cfg_dflt_en && (!cfg_drange_on || in_drange)) begin
          rsp_port_q <= DP;        rsp_dflt_q <= 1'b1; rsp_err_q <= 1'b0;
        end else begin
          rsp_port_q <= '0;        rsp_dflt_q <= 1'b0; rsp_err_q <= 1'b1;
        end
      end else if (acc) begin
        if (!all_rep) begin
          rsp_valid_q <= 1'b1;
          rsp_port_q  <= '0; rsp_dflt_q <= 1'b0; rsp_err_q <= 1'b1;
        end else if (c_hit) begin
          rsp_valid_q <= 1'b1;
          rsp_port_q  <= c_port; rsp_dflt_q <= 1'b0; rsp_err_q <= 1'b0;
        end else begin
          s2_q      <= 1'b1;
          s2_addr_q <= lk_addr;
        end
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_port  = rsp_port_q;
  assign rsp_dflt  = rsp_dflt_q;
  assign rsp_err   = rsp_err_q;

  // R1: lookups before readiness are refused next cycle
  a_r1_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !all_rep) |=> (rsp_valid && rsp_err));

  // R2: a table search always answers in the following cycle
  a_r2_search_done: assert property (@(posedge clk) disable iff (!rst_n)
    s2_q |=> (rsp_valid && lk_ready));

  // R3: a default-routed answer names the default port and no error
  a_r3_dflt_port: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_dflt) |-> (rsp_port == DP) && !rsp_err);

  // R8: an extra default range raises code 2
  a_r8_multi_dflt: assert property (@(posedge clk) disable iff (!rst_n)
    multi_dflt |=> (cfg_err_valid && (cfg_err_code == 2'd2)));

endmodule

// File: tb/addr_route_dec_test.sv
module addr_route_dec_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_dflt_en, cfg_drange_on;
  logic        prog_valid, prog_first;
  logic [1:0]  prog_port;
  logic [15:0] prog_base, prog_end;
  logic        done_valid;
  logic [1:0]  done_port;
  logic        lk_req;
  logic [15:0] lk_addr;
  logic        lk_ready, rsp_valid, rsp_dflt, rsp_err;
  logic [1:0]  rsp_port;
  logic        cfg_err_valid;
  logic [1:0]  cfg_err_code;
  logic        contain_err;
  logic [3:0]  exp_idx;
  logic        exp_valid;
  logic [15:0] exp_base, exp_end;
  logic [3:0]  exp_cnt;

  int vectors = 0;
  int fails   = 0;

  always #(CLK_P/2) clk = ~clk;

  addr_route_dec uut (
    .clk(clk), .rst_n(rst_n), .cfg_dflt_en(cfg_dflt_en), .cfg_drange_on(cfg_drange_on),
    .prog_valid(prog_valid), .prog_first(prog_first), .prog_port(prog_port),
    .prog_base(prog_base), .prog_end(prog_end),
    .done_valid(done_valid), .done_port(done_port),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_ready(lk_ready),
    .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_dflt(rsp_dflt), .rsp_err(rsp_err),
    .cfg_err_valid(cfg_err_valid), .cfg_err_code(cfg_err_code), .contain_err(contain_err),
    .exp_idx(exp_idx), .exp_valid(exp_valid), .exp_base(exp_base), .exp_end(exp_end),
    .exp_cnt(exp_cnt)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic lk_expect(input string req, input logic [15:0] a, input int lat,
                           input int port, input bit dflt, input bit err);
    int got_lat;
    @(negedge clk);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    if (rsp_valid) got_lat = 1;
    else begin
      @(negedge clk);
      got_lat = rsp_valid ? 2 : 99;
    end
    chk(req, $sformatf("latency @%h", a), got_lat, lat);
    chk(req, $sformatf("err @%h", a), rsp_err, err);
    if (!err) begin
      chk(req, $sformatf("port @%h", a), rsp_port, port);
      chk(req, $sformatf("dflt @%h", a), rsp_dflt, dflt);
    end
  endtask

  task automatic prog(input string req, input int port, input bit first,
                      input logic [15:0] b, input logic [15:0] e, input int code);
    @(negedge clk);
    prog_valid = 1'b1; prog_first = first; prog_port = 2'(port);
    prog_base = b; prog_end = e;
    @(negedge clk);
    prog_valid = 1'b0;
    chk(req, "write error code", cfg_err_valid ? cfg_err_code : 0, code);
  endtask

  task automatic done(input int port);
    @(negedge clk);
    done_valid = 1'b1; done_port = 2'(port);
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "lk_ready after reset", lk_ready, 1);
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
    chk("R7", "cfg_err_valid after reset", cfg_err_valid, 0);
    chk("R10", "contain_err after reset", contain_err, 0);
    chk("R11", "exp_cnt after reset", exp_cnt, 0);
  endtask

  task automatic t_not_ready;
    lk_expect("R1", 16'h1800, 1, 0, 0, 1);
    prog("R6", 0, 1, 16'h1000, 16'h1FFF, 0);
    prog("R6", 1, 1, 16'h2000, 16'h2FFF, 0);
    prog("R6", 1, 0, 16'h4000, 16'h40FF, 0);
    prog("R6", 2, 1, 16'h3000, 16'h3FFF, 0);
    prog("R3", 3, 1, 16'h0000, 16'h7FFF, 0);
    done(0); done(1); done(2);
    lk_expect("R1", 16'h1800, 1, 0, 0, 1);
    done(3);
  endtask

  task automatic t_cache;
    lk_expect("R2", 16'h1800, 2, 0, 0, 0);
    lk_expect("R2", 16'h1804, 1, 0, 0, 0);
    lk_expect("R2", 16'h4010, 2, 1, 0, 0);
  endtask

  task automatic t_default_paths;
    lk_expect("R4", 16'h9000, 2, 3, 1, 0);
    lk_expect("R4", 16'h9000, 2, 3, 1, 0);
    cfg_drange_on = 1'b1;
    lk_expect("R3", 16'h5000, 2, 3, 1, 0);
    lk_expect("R5", 16'h9000, 2, 0, 0, 1);
    cfg_dflt_en = 1'b0;
    lk_expect("R5", 16'h5000, 2, 0, 0, 1);
    cfg_dflt_en = 1'b1;
  endtask

  task automatic t_overlap;
    prog("R7", 2, 0, 16'h1F00, 16'h20FF, 1);
    lk_expect("R7", 16'h20F0, 2, 1, 0, 0);
    lk_expect("R7", 16'h1F80, 2, 0, 0, 0);
  endtask

  task automatic t_multi_default;
    prog("R8", 3, 0, 16'h8000, 16'h8FFF, 2);
    lk_expect("R8", 16'h8800, 2, 0, 0, 1);
    lk_expect("R8", 16'h5000, 2, 3, 1, 0);
  endtask

  task automatic t_replace_flush;
    lk_expect("R9", 16'h2100, 2, 1, 0, 0);
    lk_expect("R9", 16'h2100, 1, 1, 0, 0);
    done(1);
    lk_expect("R9", 16'h2100, 2, 1, 0, 0);
    prog("R6", 1, 1, 16'h6000, 16'h60FF, 0);
    lk_expect("R6", 16'h2100, 2, 3, 1, 0);
    lk_expect("R6", 16'h4010, 2, 3, 1, 0);
    lk_expect("R6", 16'h6010, 2, 1, 0, 0);
  endtask

  task automatic t_contain;
    chk("R10", "contain_err all inside", contain_err, 0);
    prog("R10", 2, 1, 16'h7F00, 16'h80FF, 0);
    chk("R10", "contain_err straddling", contain_err, 1);
    cfg_drange_on = 1'b0;
    @(negedge clk);
    chk("R10", "contain_err mode off", contain_err, 0);
    cfg_drange_on = 1'b1;
    prog("R10", 2, 1, 16'h3000, 16'h3FFF, 0);
    chk("R10", "contain_err after fix", contain_err, 0);
  endtask

  task automatic t_export;
    exp_idx = 4'd0;
    @(negedge clk);
    chk("R11", "idx0 valid", exp_valid, 1);
    chk("R11", "idx0 base", exp_base, 16'h0000);
    chk("R11", "idx0 end", exp_end, 16'h7FFF);
    chk("R11", "count all inside", exp_cnt, 0);
    prog("R11", 0, 0, 16'h9000, 16'h90FF, 0);
    exp_idx = 4'd1;
    @(negedge clk);
    chk("R11", "count one outside", exp_cnt, 1);
    chk("R11", "idx1 valid", exp_valid, 1);
    chk("R11", "idx1 base", exp_base, 16'h9000);
    chk("R11", "idx1 end", exp_end, 16'h90FF);
    exp_idx = 4'd2;
    @(negedge clk);
    chk("R11", "idx2 valid", exp_valid, 0);
    cfg_drange_on = 1'b0;
    @(negedge clk);
    chk("R11", "count mode off", exp_cnt, 4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_dflt_en = 1'b1; cfg_drange_on = 1'b0;
    prog_valid = 1'b0; prog_first = 1'b0; prog_port = '0;
    prog_base = '0; prog_end = '0;
    done_valid = 1'b0; done_port = '0;
    lk_req = 1'b0; lk_addr = '0; exp_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_not_ready();
    t_cache();
    t_default_paths();
    t_overlap();
    t_multi_default();
    t_replace_flush();
    t_contain();
    t_export();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule